// File: doc/BRIEF.md
# Upper-Context Shadow Save Unit

This unit sits beside a processor register file. It saves the upper half of the register context on every call, interrupt or trap, and it hands that context back on the matching return. All three kinds of entry use the same save path. The lower context is software's job and does not pass through this unit. A small last-in-first-out stack of shadow register sets takes each save in one step. The core therefore sees a short, fixed save time whenever a shadow set is free.

When every shadow set is occupied, a save first moves the oldest shadow set out to a context save memory. It does this in beats of several words each, and a link pointer selects the next free save area. The spill is then visible to the core as extra cycles. A restore pops the newest shadow set. If the shadow stack is empty, the unit refills the context from the newest save area on its own and moves the pointer back. A restore with nothing saved raises an underflow flag. A save with the shadows and the memory both full raises an overflow flag.

Top module: `ctx_save_unit`

## Requirements
- R1: A save accepted while a shadow set is free raises `done` in the cycle after the request (two cycles in total). `stall` stays low and the save does not touch the memory port.
- R2: A save accepted with every shadow set occupied first writes the oldest shadow set to the save area given by the link pointer. It uses four beats of four words, one beat per cycle, in the four cycles after the request. Beat k carries context words 4k to 4k+3, with word j at bits 32j of the context and word 4k+i at bits 32i of `mem_wdata`. `mem_addr` is area*16 + 4k. `stall` is high during the first three beats. `done` is high in the fourth beat, so the save takes five cycles. The link pointer then advances by one area.
- R3: A restore with at least one shadow set present raises `done` one cycle after the request, with `stall` low. `ctx_rd` then equals the most recently saved context that has not yet been restored.
- R4: A restore with the shadow stack empty and at least one save area in use reads the newest area in four ascending beats, in the four cycles after the request, at area*16 + 4k. `stall` is high during those beats. `done` follows in the next cycle with the refilled context on `ctx_rd`, and the link pointer moves back one area.
- R5: Any interleaving of saves and restores, including nesting deeper than the shadow stack, returns the contexts in reverse order of saving.
- R6: A restore with nothing saved pulses `err_underflow` in the next cycle, gives no `done`, makes no memory access and leaves `ctx_rd` unchanged.
- R7: A save with every shadow set and every save area occupied pulses `err_overflow` in the next cycle. It gives no `done`, makes no memory write and leaves all saved contexts unchanged.
- R8: A request is taken only in a cycle where the unit is idle (no spill, refill or completion in progress). Requests made in other cycles have no effect, and `done` is always a one-cycle pulse.
- R9: When a save and a restore are requested in the same idle cycle, the save is performed and the restore is ignored.
- R10: During reset `stall`, `done`, both error flags, `mem_we` and `mem_re` are low and `ctx_rd` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Save the upper context presented on ctx_wr |
| restore_req | input | 1 | Return the most recent saved context |
| ctx_wr | input | 512 | Upper context from the register file, 16 words |
| ctx_rd | output | 512 | Restored upper context to the register file |
| stall | output | 1 | Core must wait: spill or refill in progress |
| done | output | 1 | Save complete, or restored context valid on ctx_rd |
| err_overflow | output | 1 | Save refused, all storage occupied |
| err_underflow | output | 1 | Restore refused, nothing saved |
| mem_we | output | 1 | Write one beat to the save memory |
| mem_re | output | 1 | Read one beat from the save memory |
| mem_addr | output | 6 | Word address of the first word of the beat |
| mem_wdata | output | 128 | Beat written to the save memory |
| mem_rdata | input | 128 | Beat read from the save memory, same cycle |

## Verification
The hardest state to reach is the one where both shadow sets and every save area are occupied. Only there can the overflow path and the three-deep refill chain be seen. The bench reaches it by nesting five saves with distinct contexts: two fill the shadows and three each trigger a spill. A sixth save is then refused, and all five contexts are unwound through two shadow pops and three refills, which shows that the refused save damaged nothing. Requests made in cycles where they must be ignored are driven during a live spill, and the later restores show that they had no effect.

// File: rtl/ctxsv_pkg.sv
package ctxsv_pkg;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_ACK,
    CS_SPILL,
    CS_FILL
  } cs_state_e;

  // word address of a beat inside a save area
  function automatic int unsigned area_word(input int unsigned area,
                                            input int unsigned beat,
                                            input int unsigned words_per_area,
                                            input int unsigned words_per_beat);
    return area * words_per_area + beat * words_per_beat;
  endfunction

endpackage

// File: rtl/ctxsv_shadow_stack.sv
module ctxsv_shadow_stack #(
  parameter int NSETS = 2,
  parameter int CW    = 512,
  parameter int CNTW  = $clog2(NSETS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            spill_push,
  input  logic            pop,
  input  logic [CW-1:0]   din,
  output logic [CW-1:0]   top_q,
  output logic [CW-1:0]   oldest_q,
  output logic [CNTW-1:0] cnt_q
);
  localparam int IDXW = (NSETS > 1) ? $clog2(NSETS) : 1;

  logic [CW-1:0]   sets [NSETS];
  logic [IDXW-1:0] top_idx;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    if (g == NSETS - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (spill_push) sets[g] <= din;
        else if (push && cnt_q == CNTW'(g)) sets[g] <= din;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (spill_push) sets[g] <= sets[g+1];
        else if (push && cnt_q == CNTW'(g)) sets[g] <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (push) cnt_q <= cnt_q + 1'b1;
    else if (pop) cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    top_idx = (cnt_q == '0) ? '0 : IDXW'(cnt_q - 1'b1);
    top_q    = sets[top_idx];
    oldest_q = sets[0];
  end

endmodule

// File: rtl/ctxsv_beat_seq.sv
module ctxsv_beat_seq #(
  parameter int NBEATS = 4,
  parameter int BIDXW  = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [BIDXW-1:0] beat_q,
  output logic             last
);
  assign last = (beat_q == BIDXW'(NBEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else if (start) beat_q <= '0;
    else if (run && !last) beat_q <= beat_q + 1'b1;
  end

endmodule

// File: rtl/ctx_save_unit.sv
module ctx_save_unit
  import ctxsv_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int CTX_WORDS   = 16,
  parameter int BEAT_WORDS  = 4,
  parameter int SHADOW_SETS = 2,
  parameter int SAVE_AREAS  = 3,
  parameter int ADDR_W      = $clog2(SAVE_AREAS * CTX_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         save_req,
  input  logic                         restore_req,
  input  logic [WORD_W*CTX_WORDS-1:0]  ctx_wr,
  output logic [WORD_W*CTX_WORDS-1:0]  ctx_rd,
  output logic                         stall,
  output logic                         done,
  output logic                         err_overflow,
  output logic                         err_underflow,
  output logic                         mem_we,
  output logic                         mem_re,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W*BEAT_WORDS-1:0] mem_wdata,
  input  logic [WORD_W*BEAT_WORDS-1:0] mem_rdata
);
  localparam int CW     = WORD_W * CTX_WORDS;
  localparam int BW     = WORD_W * BEAT_WORDS;
  localparam int NBEATS = CTX_WORDS / BEAT_WORDS;
  localparam int BIDXW  = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam int CNTW   = $clog2(SHADOW_SETS + 1);
  localparam int PTRW   = $clog2(SAVE_AREAS + 1);

  cs_state_e        st_q, st_d;
  logic [CW-1:0]    stage_q, rd_q;
  logic [PTRW-1:0]  ptr_q;
  logic             ovf_q, unf_q;

  logic [CW-1:0]    top_q, oldest_q;
  logic [CNTW-1:0]  set_cnt;
  logic [BIDXW-1:0] beat_q;
  logic             beat_last;

  // named internal events
  logic idle, shadow_full, shadow_empty, mem_full, mem_empty;
  logic go_save, go_restore;
  logic save_fast, save_spill, save_reject;
  logic rest_fast, rest_fill, rest_reject;
  logic in_spill, in_fill, spill_end, fill_end;
  logic [PTRW-1:0] area_sel;

  always_comb begin
    idle         = (st_q == CS_IDLE);
    shadow_full  = (set_cnt == CNTW'(SHADOW_SETS));
    shadow_empty = (set_cnt == '0);
    mem_full     = (ptr_q == PTRW'(SAVE_AREAS));
    mem_empty    = (ptr_q == '0);
    go_save      = idle && save_req;
    go_restore   = idle && restore_req && !save_req;
    save_fast    = go_save && !shadow_full;
    save_spill   = go_save && shadow_full && !mem_full;
    save_reject  = go_save && shadow_full && mem_full;
    rest_fast    = go_restore && !shadow_empty;
    rest_fill    = go_restore && shadow_empty && !mem_empty;
    rest_reject  = go_restore && shadow_empty && mem_empty;
    in_spill     = (st_q == CS_SPILL);
    in_fill      = (st_q == CS_FILL);
    spill_end    = in_spill && beat_last;
    fill_end     = in_fill && beat_last;
    area_sel     = in_fill ? (ptr_q - 1'b1) : ptr_q;
  end

  ctxsv_shadow_stack #(
    .NSETS(SHADOW_SETS), .CW(CW), .CNTW(CNTW)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (save_fast),
    .spill_push(spill_end),
    .pop       (rest_fast),
    .din       (spill_end ? stage_q : ctx_wr),
    .top_q     (top_q),
    .oldest_q  (oldest_q),
    .cnt_q     (set_cnt)
  );

  ctxsv_beat_seq #(
    .NBEATS(NBEATS), .BIDXW(BIDXW)
  ) u_beats (
    .clk   (clk),
    .rst_n (rst_n),
    .start (save_spill || rest_fill),
    .run   (in_spill || in_fill),
    .beat_q(beat_q),
    .last  (beat_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      CS_IDLE: begin
        if (save_fast || rest_fast) st_d = CS_ACK;
        else if (save_spill)        st_d = CS_SPILL;
        else if (rest_fill)         st_d = CS_FILL;
      end
      CS_SPILL: if (beat_last) st_d = CS_IDLE;
      CS_FILL:  if (beat_last) st_d = CS_ACK;
      default:  st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CS_IDLE;
      ptr_q <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovf_q <= save_reject;
      unf_q <= rest_reject;
      if (spill_end) ptr_q <= ptr_q + 1'b1;
      else if (fill_end) ptr_q <= ptr_q - 1'b1;
      if (rest_fast) rd_q <= top_q;
      else if (in_fill) rd_q[beat_q*BW +: BW] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (save_spill) stage_q <= ctx_wr;
  end

  assign ctx_rd        = rd_q;
  assign done          = (st_q == CS_ACK) || spill_end;
  assign stall         = (in_spill && !beat_last) || in_fill;
  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;
  assign mem_we        = in_spill;
  assign mem_re        = in_fill;
  assign mem_addr      = ADDR_W'(area_word(int'(area_sel), int'(beat_q),
                                           CTX_WORDS, BEAT_WORDS));
  assign mem_wdata     = oldest_q[beat_q*BW +: BW];

endmodule

// File: rtl/ctxsv_checker.sv
module ctxsv_checker #(
  parameter int CNTW = 2,
  parameter int PTRW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            done,
  input logic            err_overflow,
  input logic            err_underflow,
  input logic            mem_we,
  input logic            mem_re,
  input logic            go_restore,
  input logic [CNTW-1:0] set_cnt,
  input logic [PTRW-1:0] area_ptr
);

  // R1
  done_not_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);

  // R2
  spill_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && stall) |=> mem_we);

  // R2
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R3
  shadow_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_restore && set_cnt != '0) |=> (done && set_cnt == $past(set_cnt) - 1'b1));

  // R4
  fill_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_re || done));

  // R6
  underflow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> (!done && !mem_re));

  // R7
  overflow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> (!done && !mem_we));

  // R7
  overflow_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> ($stable(set_cnt) && $stable(area_ptr)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind ctx_save_unit ctxsv_checker #(
  .CNTW(CNTW), .PTRW(PTRW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .done         (done),
  .err_overflow (err_overflow),
  .err_underflow(err_underflow),
  .mem_we       (mem_we),
  .mem_re       (mem_re),
  .go_restore   (go_restore),
  .set_cnt      (set_cnt),
  .area_ptr     (ptr_q)
);

// File: tb/ctx_save_unit_tb_top.sv
module ctx_save_unit_tb_top;
  localparam int CW     = 512;
  localparam int BW     = 128;
  localparam int AREAS  = 3;
  localparam int MWORDS = AREAS * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic save_req = 1'b0, restore_req = 1'b0;
  logic [CW-1:0] ctx_wr = '0, ctx_rd;
  logic stall, done, err_overflow, err_underflow, mem_we, mem_re;
  logic [5:0] mem_addr;
  logic [BW-1:0] mem_wdata, mem_rdata;

  int total = 0, bad = 0;
  int cyc = 0;

  // bench model: list of saved contexts, m of them held in memory
  logic [CW-1:0] saved [0:7];
  int n = 0, m = 0;
  logic [CW-1:0] last_rd = '0;

  always #2 clk = ~clk;

  ctx_save_unit dut_i (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .ctx_wr(ctx_wr), .ctx_rd(ctx_rd), .stall(stall), .done(done),
    .err_overflow(err_overflow), .err_underflow(err_underflow),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // save memory model, combinational read
  logic [31:0] mem [MWORDS];
  always @(posedge clk) begin
    if (mem_we)
      for (int k = 0; k < 4; k++) mem[int'(mem_addr) + k] <= mem_wdata[32*k +: 32];
  end
  always_comb begin
    for (int k = 0; k < 4; k++)
      mem_rdata[32*k +: 32] = (int'(mem_addr) + k < MWORDS) ? mem[int'(mem_addr) + k] : 32'h0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [CW-1:0] act,
                     input logic [CW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mkctx(input int s);
    logic [CW-1:0] r;
    for (int j = 0; j < 16; j++) r[32*j +: 32] = 32'hA5000000 ^ (s << 12) ^ (j * 32'h0101);
    return r;
  endfunction

  // save: kind chosen from the bench's own occupancy model
  task automatic do_save(input logic [CW-1:0] c, input bit poke);
    @(negedge clk);
    save_req = 1'b1;
    ctx_wr = c;
    @(negedge clk);
    save_req = 1'b0;
    if (n - m < 2) begin
      chk(done == 1'b1 && stall == 1'b0, "R1 fast save done", CW'(done), CW'(1));
      chk(mem_we == 1'b0 && err_overflow == 1'b0, "R1 no memory write", CW'(mem_we), CW'(0));
      saved[n] = c;
      n++;
    end else if (m == AREAS) begin
      chk(err_overflow == 1'b1, "R7 overflow flag", CW'(err_overflow), CW'(1));
      chk(done == 1'b0 && mem_we == 1'b0, "R7 no done no write", CW'({done, mem_we}), CW'(0));
    end else begin
      if (poke) restore_req = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (k == 3) restore_req = 1'b0;
        chk(mem_we == 1'b1 && mem_re == 1'b0, "R2 spill beat write", CW'({mem_we, mem_re}), CW'(2));
        chk(int'(mem_addr) == m * 16 + 4 * k, "R2 spill address", CW'(mem_addr), CW'(m * 16 + 4 * k));
        chk(mem_wdata == saved[m][BW*k +: BW], "R2 spill data", CW'(mem_wdata), CW'(saved[m][BW*k +: BW]));
        chk(stall == (k < 3) && done == (k == 3), "R2 stall/done timing",
            CW'({stall, done}), CW'({k < 3, k == 3}));
        if (poke) chk(done == (k == 3), "R8 request ignored while busy", CW'(done), CW'(k == 3));
        if (k < 3) @(negedge clk);
      end
      saved[n] = c;
      n++;
      m++;
    end
  endtask

  task automatic do_restore();
    @(negedge clk);
    restore_req = 1'b1;
    @(negedge clk);
    restore_req = 1'b0;
    if (n == 0) begin
      chk(err_underflow == 1'b1 && done == 1'b0, "R6 underflow flag", CW'({err_underflow, done}), CW'(2));
      chk(mem_re == 1'b0 && ctx_rd == last_rd, "R6 ctx_rd unchanged", ctx_rd, last_rd);
    end else if (n > m) begin
      chk(done == 1'b1 && stall == 1'b0 && mem_re == 1'b0, "R3 shadow restore done",
          CW'({done, stall, mem_re}), CW'(4));
      chk(ctx_rd == saved[n-1], "R3 R5 restored context", ctx_rd, saved[n-1]);
      n--;
      last_rd = ctx_rd;
    end else begin
      for (int k = 0; k < 4; k++) begin
        chk(mem_re == 1'b1 && stall == 1'b1 && done == 1'b0, "R4 refill beat",
            CW'({mem_re, stall, done}), CW'(6));
        chk(int'(mem_addr) == (m - 1) * 16 + 4 * k, "R4 refill address",
            CW'(mem_addr), CW'((m - 1) * 16 + 4 * k));
        @(negedge clk);
      end
      chk(done == 1'b1 && stall == 1'b0, "R4 refill done", CW'({done, stall}), CW'(2));
      chk(ctx_rd == saved[n-1], "R4 R5 refilled context", ctx_rd, saved[n-1]);
      n--;
      m--;
      last_rd = ctx_rd;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({stall, done, err_overflow, err_underflow, mem_we, mem_re} == 6'b0,
        "R10 outputs low in reset", CW'({stall, done, err_overflow, err_underflow, mem_we, mem_re}), CW'(0));
    chk(ctx_rd == '0, "R10 ctx_rd zero", ctx_rd, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_single();
    do_save(mkctx(1), 1'b0);
    do_restore();
  endtask

  task automatic t_nested_deep();
    for (int i = 0; i < 5; i++) do_save(mkctx(10 + i), 1'b0);
    do_save(mkctx(99), 1'b0);
    for (int i = 0; i < 5; i++) do_restore();
    do_restore();
  endtask

  task automatic t_ignore_busy();
    do_save(mkctx(20), 1'b0);
    do_save(mkctx(21), 1'b0);
    do_save(mkctx(22), 1'b1);
    for (int i = 0; i < 3; i++) do_restore();
  endtask

  task automatic t_both_at_once();
    do_save(mkctx(30), 1'b0);
    do_restore();
    do_save(mkctx(31), 1'b0);
    @(negedge clk);
    save_req = 1'b1;
    restore_req = 1'b1;
    ctx_wr = mkctx(32);
    @(negedge clk);
    save_req = 1'b0;
    restore_req = 1'b0;
    chk(done == 1'b1 && ctx_rd == last_rd, "R9 save wins, ctx_rd kept", ctx_rd, last_rd);
    saved[n] = mkctx(32);
    n++;
    do_restore();
    do_restore();
  endtask

  initial begin
    t_reset();
    do_restore();
    t_single();
    t_nested_deep();
    t_ignore_busy();
    t_both_at_once();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule